// File: doc/BRIEF.md
# Smart Card Clock and ETU Generator

This block derives the two timing references of an asynchronous smart card interface from the system clock. The first is the card clock that drives the card's clock pin. Its period is set by a programmable divisor. The second is the elementary time unit (ETU), the bit time of the serial link. The ETU is a whole number of card clock periods, given by the ratio of the clock rate conversion factor F to the baud adjustment factor D, plus an optional fine-tune count. The block emits a one-cycle tick at the end of each ETU and a one-cycle strobe at the middle of each ETU, where a receiver samples the data line.

A configuration load captures a new divisor, rate pair and tune value, and restarts both counters from zero. The card clock can be parked at a chosen level, either low or high. The park request and the later resume both take effect only at a card clock period boundary. A status output shows whether the clock is actually parked, so a controller can poll it until the change is complete. Bit tick generation runs only while the card is marked active.

Top module: `scc_clk_etu`

## Requirements
- R1: With divisor value N on `cfg_div`, the card clock period is N+1 system clocks. The high phase lasts floor((N+1)/2) clocks and comes first after each period boundary. A loaded N of 0 acts as N = 1.
- R2: One ETU lasts P = (N+1)*R + T system clocks, where T is `cfg_tune` and R is selected by `cfg_fd`: 2'b00 gives 372 (F=372, D=1), 2'b01 gives 64 (F=512, D=8), 2'b10 gives 128 (F=512, D=4), and 2'b11 gives 372. After a load is sampled at edge L, with the card active throughout, `etu_tick` pulses after edges L+k*P for k >= 1.
- R3: After reset, the divisor is DEF_DIV, the rate code is 2'b00 and the tune value is 0, so one ETU is (DEF_DIV+1)*372 clocks. `card_clk` is 1 and `etu_tick`, `half_tick` and `clk_stopped` are 0.
- R4: `half_tick` pulses after edges L+floor(P/2)+1+(k-1)*P for k >= 1, and never in the same cycle as `etu_tick`.
- R5: A load restarts the card clock and ETU counters at zero. No tick or strobe follows the edge that samples a load, even when that edge would have ended an ETU.
- R6: While `card_active` is 0, the ETU counter is held at zero and neither `etu_tick` nor `half_tick` pulses.
- R7: A park request takes effect at the next card clock period boundary, at most N+1 clocks later. From then on `card_clk` holds the `stop_level` value sampled at that boundary. Changing `stop_level` while parked has no effect. `clk_stopped` is 1 exactly while the clock is parked.
- R8: Resuming also takes effect at a period boundary, and `clk_stopped` returns to 0 within N+1 clocks. Apart from a pulse cut by a load, no card clock phase is shorter than floor((N+1)/2) clocks.
- R9: `etu_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture the configuration inputs and restart the counters |
| cfg_div | input | DIV_W | Card clock divisor N |
| cfg_fd | input | 2 | Rate pair selection code |
| cfg_tune | input | TUNE_W | Extra system clocks added to each ETU |
| card_active | input | 1 | Card session active; enables ETU counting |
| stop_req | input | 1 | Request to park the card clock |
| stop_level | input | 1 | Level at which the parked clock is held |
| card_clk | output | 1 | Card clock pin |
| etu_tick | output | 1 | One-cycle pulse at the end of each ETU |
| half_tick | output | 1 | One-cycle pulse at the middle of each ETU |
| clk_stopped | output | 1 | Card clock is currently parked |

## Verification
The two functions that can fall in the same cycle are the configuration load and the natural end of an ETU. When they coincide, the load must win and the tick must be dropped. The bench provokes this by timing a second load to land on the exact edge at which the running sequence would produce its second tick. The scoreboard holds no entry for that tick, so a stray pulse would be matched against the first tick of the new sequence and reported. A park request arriving in the middle of a card clock period is also exercised. There the bench checks that the status lag stays within one period and that the held level does not change afterwards.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef enum logic [1:0] {
    FD_372_1 = 2'b00,
    FD_512_8 = 2'b01,
    FD_512_4 = 2'b10,
    FD_SPARE = 2'b11
  } fd_sel_e;

  localparam int RATIO_W = 9;

  // card clocks per ETU for a rate selection code
  function automatic logic [RATIO_W-1:0] fd_ratio(input logic [1:0] sel);
    case (fd_sel_e'(sel))
      FD_512_8: fd_ratio = RATIO_W'(64);
      FD_512_4: fd_ratio = RATIO_W'(128);
      default:  fd_ratio = RATIO_W'(372);
    endcase
  endfunction

endpackage

// File: rtl/scc_cfg.sv
module scc_cfg
  import scc_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int TUNE_W  = 4,
  parameter int ETU_W   = 18,
  parameter int DEF_DIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [1:0]        cfg_fd,
  input  logic [TUNE_W-1:0] cfg_tune,
  output logic [DIV_W-1:0]  div_q,
  output logic [ETU_W-1:0]  etu_div_q,
  output logic [ETU_W-1:0]  half_pt_q
);

  localparam logic [DIV_W-1:0] RST_DIV  = DIV_W'(DEF_DIV);
  localparam logic [ETU_W-1:0] RST_ETU  = ETU_W'((DEF_DIV + 1) * 372 - 1);
  localparam logic [ETU_W-1:0] RST_HALF = ETU_W'(((DEF_DIV + 1) * 372) / 2);

  logic [DIV_W-1:0] div_eff, div_nxt;
  logic [ETU_W-1:0] etu_new, etu_nxt, half_nxt;

  always_comb begin
    div_eff  = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
    etu_new  = (ETU_W'(div_eff) + ETU_W'(1)) * ETU_W'(fd_ratio(cfg_fd))
               - ETU_W'(1) + ETU_W'(cfg_tune);
    div_nxt  = div_q;
    etu_nxt  = etu_div_q;
    half_nxt = half_pt_q;
    if (cfg_load) begin
      div_nxt  = div_eff;
      etu_nxt  = etu_new;
      half_nxt = (etu_new + ETU_W'(1)) >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= RST_DIV;
      etu_div_q <= RST_ETU;
      half_pt_q <= RST_HALF;
    end else begin
      div_q     <= div_nxt;
      etu_div_q <= etu_nxt;
      half_pt_q <= half_nxt;
    end
  end

endmodule

// File: rtl/scc_clkgen.sv
module scc_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_q,
  input  logic             stop_req,
  input  logic             stop_level,
  output logic             card_clk,
  output logic             parked
);

  logic [DIV_W-1:0] cc_q, cc_nxt;
  logic [DIV_W:0]   hi_cnt;
  logic             run_q, run_nxt;
  logic             lvl_q, lvl_nxt;
  logic             pin_q, pin_nxt;
  logic             boundary;

  always_comb begin
    hi_cnt   = ({1'b0, div_q} + {{DIV_W{1'b0}}, 1'b1}) >> 1;
    boundary = (cc_q == div_q);
    cc_nxt   = (restart || boundary) ? '0 : cc_q + DIV_W'(1);
    run_nxt  = boundary ? !stop_req : run_q;
    lvl_nxt  = (boundary && stop_req && run_q) ? stop_level : lvl_q;
    pin_nxt  = run_nxt ? ({1'b0, cc_nxt} < hi_cnt) : lvl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q  <= '0;
      run_q <= 1'b1;
      lvl_q <= 1'b0;
      pin_q <= 1'b1;
    end else begin
      cc_q  <= cc_nxt;
      run_q <= run_nxt;
      lvl_q <= lvl_nxt;
      pin_q <= pin_nxt;
    end
  end

  assign card_clk = pin_q;
  assign parked   = !run_q;

endmodule

// File: rtl/scc_etugen.sv
module scc_etugen #(
  parameter int ETU_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic [ETU_W-1:0] etu_div,
  input  logic [ETU_W-1:0] half_pt,
  output logic             etu_tick,
  output logic             half_tick
);

  logic [ETU_W-1:0] cnt_q, cnt_nxt;
  logic             tick_nxt, half_nxt, live;

  always_comb begin
    live     = active && !restart;
    cnt_nxt  = (!live || cnt_q == etu_div) ? '0 : cnt_q + ETU_W'(1);
    tick_nxt = live && (cnt_q == etu_div);
    half_nxt = live && (cnt_q == half_pt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      etu_tick  <= 1'b0;
      half_tick <= 1'b0;
    end else begin
      cnt_q     <= cnt_nxt;
      etu_tick  <= tick_nxt;
      half_tick <= half_nxt;
    end
  end

endmodule

// File: rtl/scc_clk_etu.sv
module scc_clk_etu #(
  parameter int DIV_W   = 8,
  parameter int TUNE_W  = 4,
  parameter int DEF_DIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [1:0]        cfg_fd,
  input  logic [TUNE_W-1:0] cfg_tune,
  input  logic              card_active,
  input  logic              stop_req,
  input  logic              stop_level,
  output logic              card_clk,
  output logic              etu_tick,
  output logic              half_tick,
  output logic              clk_stopped
);

  localparam int ETU_W = DIV_W + 10;

  logic [DIV_W-1:0] div_q;
  logic [ETU_W-1:0] etu_div_q, half_pt_q;

  scc_cfg #(
    .DIV_W(DIV_W), .TUNE_W(TUNE_W), .ETU_W(ETU_W), .DEF_DIV(DEF_DIV)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_div(cfg_div),
    .cfg_fd(cfg_fd), .cfg_tune(cfg_tune), .div_q(div_q),
    .etu_div_q(etu_div_q), .half_pt_q(half_pt_q)
  );

  scc_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .restart(cfg_load), .div_q(div_q),
    .stop_req(stop_req), .stop_level(stop_level),
    .card_clk(card_clk), .parked(clk_stopped)
  );

  scc_etugen #(.ETU_W(ETU_W)) u_etu (
    .clk(clk), .rst_n(rst_n), .restart(cfg_load), .active(card_active),
    .etu_div(etu_div_q), .half_pt(half_pt_q),
    .etu_tick(etu_tick), .half_tick(half_tick)
  );

endmodule

// File: rtl/scc_clk_etu_chk.sv
module scc_clk_etu_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             card_active,
  input logic             card_clk,
  input logic             etu_tick,
  input logic             half_tick,
  input logic             clk_stopped,
  input logic [DIV_W-1:0] div_q
);

  logic           prev_q, cut_q;
  logic [DIV_W:0] run_q, hi_min;

  assign hi_min = ({1'b0, div_q} + {{DIV_W{1'b0}}, 1'b1}) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      run_q  <= '0;
      cut_q  <= 1'b0;
    end else begin
      prev_q <= card_clk;
      if (card_clk != prev_q) run_q <= {{DIV_W{1'b0}}, 1'b1};
      else if (run_q != '1)   run_q <= run_q + {{DIV_W{1'b0}}, 1'b1};
      if (cfg_load)                 cut_q <= 1'b1;
      else if (card_clk != prev_q)  cut_q <= 1'b0;
    end
  end

  AST_TICK_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !card_active |=> (!etu_tick && !half_tick)); // R6
  AST_LOAD_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!etu_tick && !half_tick)); // R5
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    etu_tick |=> !etu_tick); // R9
  AST_HALF_APART: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> !etu_tick); // R4
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stopped && $past(clk_stopped)) |-> $stable(card_clk)); // R7
  AST_MIN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((card_clk != prev_q) && !cut_q) |-> (run_q >= hi_min)); // R8

endmodule

bind scc_clk_etu scc_clk_etu_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .card_active(card_active),
  .card_clk(card_clk), .etu_tick(etu_tick), .half_tick(half_tick),
  .clk_stopped(clk_stopped), .div_q(div_q)
);

// File: tb/sim_scc_clk_etu.sv
`timescale 1ns/1ps
module sim_scc_clk_etu;
  localparam int DIV_W = 8, TUNE_W = 4, DEF_DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load, card_active, stop_req, stop_level;
  logic [DIV_W-1:0] cfg_div;
  logic [1:0] cfg_fd;
  logic [TUNE_W-1:0] cfg_tune;
  logic card_clk, etu_tick, half_tick, clk_stopped;

  always #2 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nerr = 0;
  bit sb_on = 1'b0;
  longint qt[$], qh[$];

  scc_clk_etu #(.DIV_W(DIV_W), .TUNE_W(TUNE_W), .DEF_DIV(DEF_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_div(cfg_div),
    .cfg_fd(cfg_fd), .cfg_tune(cfg_tune), .card_active(card_active),
    .stop_req(stop_req), .stop_level(stop_level), .card_clk(card_clk),
    .etu_tick(etu_tick), .half_tick(half_tick), .clk_stopped(clk_stopped)
  );

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic longint ratio(input int fd);
    case (fd)
      1: ratio = 64;
      2: ratio = 128;
      default: ratio = 372;
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_on) begin
      if (etu_tick) begin
        if (qt.size() == 0) chk(1'b0, "R5 unexpected etu_tick at cycle", cyc, -1);
        else begin
          longint e;
          e = qt.pop_front();
          chk(cyc == e, "R2 etu_tick cycle", cyc, e);
        end
      end
      if (half_tick) begin
        if (qh.size() == 0) chk(1'b0, "R4 unexpected half_tick at cycle", cyc, -1);
        else begin
          longint e;
          e = qh.pop_front();
          chk(cyc == e, "R4 half_tick cycle", cyc, e);
        end
      end
    end
  end

  task automatic wait_cyc(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  // driver: called at a negedge; pushes expected tick and strobe cycles
  task automatic start_seq(input int div, input int fd, input int tune, input int n,
                           output longint L, output longint P);
    longint nn, h;
    nn = (div == 0) ? 1 : div;
    cfg_div = DIV_W'(div); cfg_fd = 2'(fd); cfg_tune = TUNE_W'(tune);
    cfg_load = 1'b1; card_active = 1'b1;
    L = cyc + 1;
    P = (nn + 1) * ratio(fd) + tune;
    h = P / 2;
    for (int m = 1; m <= n; m++) begin
      qt.push_back(L + P * m);
      qh.push_back(L + h + 1 + P * (m - 1));
    end
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic end_seq(input longint t);
    wait_cyc(t);
    card_active = 1'b0;
    repeat (2) @(negedge clk);
    chk(qt.size() == 0, "R2 pending etu_tick entries", qt.size(), 0);
    chk(qh.size() == 0, "R4 pending half_tick entries", qh.size(), 0);
  endtask

  task automatic measure_clk(input int n, input string tag);
    logic prev;
    longint t0;
    int hi;
    prev = card_clk;
    @(negedge clk);
    while (!( !prev && card_clk)) begin prev = card_clk; @(negedge clk); end
    t0 = cyc; hi = 0;
    while (card_clk) begin hi++; @(negedge clk); end
    prev = card_clk;
    while (!( !prev && card_clk)) begin prev = card_clk; @(negedge clk); end
    chk(cyc - t0 == n + 1, {tag, " card clock period"}, cyc - t0, n + 1);
    chk(hi == (n + 1) / 2, {tag, " card clock high phase"}, hi, (n + 1) / 2);
  endtask

  task automatic load_div(input int div);
    cfg_div = DIV_W'(div); cfg_fd = 2'b00; cfg_tune = '0; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic park_check(input logic lvl, input int n);
    longint t0;
    bit held;
    stop_req = 1'b1; stop_level = lvl; t0 = cyc;
    while (!clk_stopped && cyc - t0 < n + 3) @(negedge clk);
    chk(clk_stopped == 1'b1, "R7 clk_stopped after park request", clk_stopped, 1);
    chk(cyc - t0 <= n + 1, "R7 park latency", cyc - t0, n + 1);
    stop_level = ~lvl;   // must be ignored while parked
    held = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (card_clk != lvl) held = 1'b0;
    end
    chk(held, "R7 parked level held", card_clk, lvl);
    stop_req = 1'b0; t0 = cyc;
    while (clk_stopped && cyc - t0 < n + 3) @(negedge clk);
    chk(clk_stopped == 1'b0, "R8 clk_stopped after resume", clk_stopped, 0);
    chk(cyc - t0 <= n + 1, "R8 resume latency", cyc - t0, n + 1);
    measure_clk(n, "R8 after resume");
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    longint L, P, L2, P2, t;
    int cnt;
    cfg_load = 1'b0; cfg_div = '0; cfg_fd = 2'b00; cfg_tune = '0;
    card_active = 1'b0; stop_req = 1'b0; stop_level = 1'b0;
    repeat (3) @(negedge clk);
    chk(card_clk == 1'b1, "R3 reset card_clk", card_clk, 1);
    chk(etu_tick == 1'b0 && half_tick == 1'b0, "R3 reset ticks", etu_tick, 0);
    chk(clk_stopped == 1'b0, "R3 reset clk_stopped", clk_stopped, 0);
    rst_n = 1'b1;

    measure_clk(DEF_DIV, "R3 default");
    card_active = 1'b1;
    do @(negedge clk); while (!etu_tick);
    t = cyc;
    do @(negedge clk); while (!etu_tick);
    chk(cyc - t == (DEF_DIV + 1) * 372, "R3 default ETU length", cyc - t, (DEF_DIV + 1) * 372);
    card_active = 1'b0;
    repeat (2) @(negedge clk);

    sb_on = 1'b1;
    start_seq(1, 1, 0, 3, L, P);  end_seq(L + P * 3);   // R2 F/D 512/8
    start_seq(5, 2, 0, 2, L, P);  end_seq(L + P * 2);   // R2 F/D 512/4
    start_seq(2, 0, 5, 2, L, P);  end_seq(L + P * 2);   // R2 tune adds clocks
    start_seq(0, 3, 0, 1, L, P);  end_seq(L + P);       // R1 zero divisor acts as 1

    // R5: load lands on the edge that would end the second ETU
    start_seq(1, 1, 0, 1, L, P);
    qh.push_back(L + P + P / 2 + 1);
    wait_cyc(L + 2 * P - 1);
    start_seq(2, 2, 0, 2, L2, P2);
    chk(L2 == L + 2 * P, "R5 collision load alignment", L2, L + 2 * P);
    end_seq(L2 + P2 * 2);

    // R6: inactive card, no ticks
    card_active = 1'b0; cnt = 0;
    repeat (3000) begin
      @(negedge clk);
      if (etu_tick || half_tick) cnt++;
    end
    chk(cnt == 0, "R6 ticks while inactive", cnt, 0);
    sb_on = 1'b0;

    load_div(4);
    measure_clk(4, "R1 odd period");
    load_div(7);
    measure_clk(7, "R1 even period");
    park_check(1'b0, 7);
    park_check(1'b1, 7);

    summary();
    $finish;
  end

endmodule